// File: doc/BRIEF.md
# Two-Byte Token Bridge

The bridge joins two modules that agree on a token of two bytes but signal it differently. The sender frames each token with a start strobe: a cycle with start high carries the leading byte, and the cycle after it carries the trailing byte. Any number of idle cycles may come between frames. The receiver expects a trigger-framed sequence: a cycle with trigger high drives the leading byte, and the cycle after it, with trigger low, drives the trailing byte. Between these, trigger stays low for any number of wait cycles. The bridge never interprets the byte values.

Finished tokens go into a small queue whose size is counted in whole tokens. The input side can therefore run ahead of the output side. A sideband ready flag holds the sender back when no room is left for another token. Two small state machines, one per side, sequence the transfers. A synchronous active-high reset empties the queue and returns both sides to idle.

Top module: `tok_bridge`

## Requirements
- R1: After reset, in_ready is 1, out_trig is 0 and out_data is 0.
- R2: A cycle with in_start=1 and in_ready=1, while no frame is in progress, captures in_data as the leading byte. The next cycle captures in_data as the trailing byte, whatever in_start is in that cycle.
- R3: Each token leaves as exactly two cycles: out_trig=1 with the leading byte on out_data, then out_trig=0 with the trailing byte. out_trig is never high in two consecutive cycles.
- R4: A token's out_trig cycle comes no earlier than the cycle after its trailing byte was captured. When the queue is empty and the output is idle, it comes in exactly that cycle.
- R5: Tokens leave in the order they arrived.
- R6: The queue holds at most QUEUE_TOKENS tokens (default 2, minimum 1). Tokens accepted minus tokens emitted never exceeds that number. in_ready is 0 whenever the held tokens plus a token in capture equal QUEUE_TOKENS.
- R7: in_start is ignored in any cycle where in_ready is 0.
- R8: When no complete token is buffered, out_trig is 0 and out_data is 0.
- R9: A reset asserted in the middle of traffic drops every buffered and partly captured token.
- R10: Byte values pass through unchanged for every 8-bit pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Marks the leading-byte cycle of an input frame |
| in_data | input | BYTE_W | Input byte bus |
| in_ready | output | 1 | High when another frame may start |
| out_trig | output | 1 | Marks the leading-byte cycle of an output frame |
| out_data | output | BYTE_W | Output byte bus, zero while waiting |

## Verification
Capturing a trailing byte and popping a finished token can fall on the same clock edge. So can starting a new frame and emitting the leading byte of the previous token. Back-to-back frames with start held high provoke both overlaps at the default depth. A depth-one instance under the same traffic makes the full condition and the ignored start recur every few cycles. Each cycle is judged against a bench model of the queue, built from the requirements, that compares ready, trigger and bus.

// File: rtl/tok_bridge_pkg.sv
package tok_bridge_pkg;

  typedef enum logic {RX_IDLE, RX_TAIL} rx_state_e;
  typedef enum logic {TX_WAIT, TX_TAIL} tx_state_e;

  // room for another frame once held tokens plus a frame in capture are counted
  function automatic logic has_room(int unsigned held, logic pending, int unsigned cap);
    return (held + 32'(pending)) < cap;
  endfunction

  // ring pointer advance over a depth of slots
  function automatic int unsigned ring_next(int unsigned ptr, int unsigned slots);
    return (ptr + 1 == slots) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/tok_rx.sv
module tok_rx #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [BYTE_W-1:0]   data,
  input  logic                ready,
  output logic                accept,
  output logic                push,
  output logic                busy,
  output logic [2*BYTE_W-1:0] push_tok
);
  import tok_bridge_pkg::*;

  rx_state_e           state_q;
  logic [BYTE_W-1:0]   lead_q;

  assign accept   = (state_q == RX_IDLE) && start && ready;
  assign busy     = (state_q == RX_TAIL);
  assign push     = busy;
  assign push_tok = {lead_q, data};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      lead_q  <= '0;
    end else begin
      if (accept) begin
        lead_q  <= data;
        state_q <= RX_TAIL;
      end else if (busy) begin
        state_q <= RX_IDLE;
      end
    end
  end
endmodule

// File: rtl/tok_queue.sv
module tok_queue #(
  parameter int BYTE_W = 8,
  parameter int TOKENS = 2,
  localparam int TOK_W = 2 * BYTE_W,
  localparam int PTR_W = (TOKENS > 1) ? $clog2(TOKENS) : 1,
  localparam int CNT_W = $clog2(TOKENS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TOK_W-1:0] push_tok,
  input  logic             pop,
  output logic [TOK_W-1:0] head_tok,
  output logic [CNT_W-1:0] count
);
  import tok_bridge_pkg::*;

  logic [TOK_W-1:0] slot_q [TOKENS];
  logic [PTR_W-1:0] wr_q, rd_q;

  generate
    for (genvar g = 0; g < TOKENS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) slot_q[g] <= '0;
        else if (push && (int'(wr_q) == g)) slot_q[g] <= push_tok;
      end
    end
  endgenerate

  assign head_tok = slot_q[rd_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= PTR_W'(ring_next(int'(wr_q), TOKENS));
      if (pop)  rd_q <= PTR_W'(ring_next(int'(rd_q), TOKENS));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tok_tx.sv
module tok_tx #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                have_tok,
  input  logic [2*BYTE_W-1:0] head_tok,
  output logic                trig,
  output logic [BYTE_W-1:0]   data,
  output logic                launch,
  output logic                pop
);
  import tok_bridge_pkg::*;

  tx_state_e state_q;

  always_comb begin
    launch = 1'b0;
    pop    = 1'b0;
    trig   = 1'b0;
    data   = '0;
    if (state_q == TX_WAIT) begin
      if (have_tok) begin
        launch = 1'b1;
        trig   = 1'b1;
        data   = head_tok[2*BYTE_W-1:BYTE_W];
      end
    end else begin
      pop  = 1'b1;
      data = head_tok[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         state_q <= TX_WAIT;
    else if (launch) state_q <= TX_TAIL;
    else if (pop)    state_q <= TX_WAIT;
  end
endmodule

// File: rtl/tok_bridge.sv
module tok_bridge #(
  parameter int BYTE_W       = 8,
  parameter int QUEUE_TOKENS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_start,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_trig,
  output logic [BYTE_W-1:0] out_data
);
  import tok_bridge_pkg::*;

  localparam int TOK_W = 2 * BYTE_W;
  localparam int CNT_W = $clog2(QUEUE_TOKENS + 1);

  logic             rx_accept, rx_push, rx_busy;
  logic [TOK_W-1:0] rx_tok, head_tok;
  logic             tx_launch, tx_pop;
  logic [CNT_W-1:0] q_count;

  assign in_ready = has_room(int'(q_count), rx_busy, QUEUE_TOKENS);

  tok_rx #(.BYTE_W(BYTE_W)) rx_i (
    .clk(clk), .rst(rst), .start(in_start), .data(in_data), .ready(in_ready),
    .accept(rx_accept), .push(rx_push), .busy(rx_busy), .push_tok(rx_tok)
  );

  tok_queue #(.BYTE_W(BYTE_W), .TOKENS(QUEUE_TOKENS)) q_i (
    .clk(clk), .rst(rst), .push(rx_push), .push_tok(rx_tok), .pop(tx_pop),
    .head_tok(head_tok), .count(q_count)
  );

  tok_tx #(.BYTE_W(BYTE_W)) tx_i (
    .clk(clk), .rst(rst), .have_tok(q_count != '0), .head_tok(head_tok),
    .trig(out_trig), .data(out_data), .launch(tx_launch), .pop(tx_pop)
  );
endmodule

// File: rtl/tok_bridge_chk.sv
module tok_bridge_chk #(
  parameter int BYTE_W       = 8,
  parameter int QUEUE_TOKENS = 2,
  parameter int CW           = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_start,
  input logic              in_ready,
  input logic              out_trig,
  input logic [BYTE_W-1:0] out_data,
  input logic              rx_accept,
  input logic              rx_push,
  input logic              tx_launch,
  input logic              tx_pop,
  input logic [CW-1:0]     q_count
);
  int unsigned accepted_q, emitted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      accepted_q <= 0;
      emitted_q  <= 0;
    end else begin
      if (rx_push) accepted_q <= accepted_q + 1;
      if (tx_pop)  emitted_q  <= emitted_q + 1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_trig && out_data == '0));
  assert_lead_then_tail_R2: assert property (@(posedge clk) disable iff (rst)
    rx_accept |=> rx_push);
  assert_trig_single_R3: assert property (@(posedge clk) disable iff (rst)
    out_trig |=> !out_trig);
  assert_launch_then_pop_R3: assert property (@(posedge clk) disable iff (rst)
    tx_launch |=> tx_pop);
  assert_earliest_out_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_push && q_count == '0) |=> out_trig);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(q_count) <= QUEUE_TOKENS) && (accepted_q - emitted_q <= QUEUE_TOKENS));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (in_start && !in_ready && !rx_push) |=> !rx_push);
  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
    (q_count == '0) |-> (!out_trig && out_data == '0));
  assert_reset_empties_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q_count == '0 && !rx_push));
endmodule

bind tok_bridge tok_bridge_chk #(.BYTE_W(BYTE_W), .QUEUE_TOKENS(QUEUE_TOKENS), .CW(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .in_start(in_start), .in_ready(in_ready), .out_trig(out_trig),
  .out_data(out_data), .rx_accept(rx_accept), .rx_push(rx_push), .tx_launch(tx_launch),
  .tx_pop(tx_pop), .q_count(q_count)
);

// File: tb/tok_bridge_tb_top.sv
module tok_bridge_tb_unit #(
  parameter int DEPTH = 2,
  parameter int SEED  = 1
) (
  input  logic clk,
  output logic done,
  output int   checks,
  output int   fails
);
  logic       rst, in_start, in_ready, out_trig;
  logic [7:0] in_data, out_data;

  tok_bridge #(.BYTE_W(8), .QUEUE_TOKENS(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_start(in_start), .in_data(in_data),
    .in_ready(in_ready), .out_trig(out_trig), .out_data(out_data)
  );

  logic [15:0] q[$];
  int          rph, tph;
  logic [7:0]  lead;
  logic        e_ready, e_trig;
  logic [7:0]  e_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s depth=%0d actual=%0h expected=%0h at %0t", tag, DEPTH, act, exp, $time);
    end
  endtask

  task automatic expect_now();
    e_ready = (q.size() + rph) < DEPTH;
    if (tph == 0) begin
      e_trig = q.size() > 0;
      e_data = (q.size() > 0) ? q[0][15:8] : 8'h00;
    end else begin
      e_trig = 1'b0;
      e_data = q[0][7:0];
    end
  endtask

  initial begin
    done = 0; checks = 0; fails = 0;
    rst = 1; in_start = 0; in_data = 0;
    rph = 0; tph = 0; lead = 0;
    void'($urandom(SEED));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: idle values straight after reset
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_trig == 1'b0, "R1 out_trig", out_trig, 0);
    chk(out_data == 8'h00, "R1 out_data", out_data, 0);
    for (int cyc = 0; cyc < 450; cyc++) begin
      expect_now();
      // R6 R7: ready follows held tokens plus a frame in capture
      chk(in_ready == e_ready, "R6 R7 in_ready", in_ready, e_ready);
      // R3 R4 R8: trigger framing, earliest launch, idle wait
      chk(out_trig == e_trig, "R3 R4 R8 out_trig", out_trig, e_trig);
      // R2 R5 R10: byte order within and across tokens, values intact
      chk(out_data == e_data, "R2 R5 R10 out_data", out_data, e_data);
      chk(q.size() <= DEPTH, "R6 occupancy", q.size(), DEPTH);
      if (cyc < 150)      in_start = 1'b1;
      else if (cyc < 300) in_start = 1'($urandom % 2);
      else                in_start = ($urandom % 4) == 0;
      in_data = 8'($urandom);
      rst = (cyc == 200);
      if (rst) begin
        q.delete(); rph = 0; tph = 0;
        @(negedge clk);
        rst = 0;
        // R9: traffic in flight is discarded
        chk(in_ready == 1'b1 && out_trig == 1'b0 && out_data == 8'h00,
            "R9 idle after reset", {in_ready, out_trig, out_data}, 10'h200);
        continue;
      end
      if (tph == 1) begin
        void'(q.pop_front());
        tph = 0;
      end else if (q.size() > 0) begin
        tph = 1;
      end
      if (rph == 1) begin
        q.push_back({lead, in_data});
        rph = 0;
      end else if (in_start && e_ready) begin
        lead = in_data;
        rph = 1;
      end
      @(negedge clk);
    end
    done = 1;
  end
endmodule

module tok_bridge_tb_top;
  logic clk = 0;
  always #10 clk = ~clk;

  logic d_a, d_b;
  int   c_a, c_b, f_a, f_b;
  int   cycles = 0;

  tok_bridge_tb_unit #(.DEPTH(2), .SEED(7))  unit_d2 (.clk(clk), .done(d_a), .checks(c_a), .fails(f_a));
  tok_bridge_tb_unit #(.DEPTH(1), .SEED(11)) unit_d1 (.clk(clk), .done(d_b), .checks(c_b), .fails(f_b));

  initial begin
    int total_fail;
    while (!(d_a === 1'b1 && d_b === 1'b1) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    total_fail = f_a + f_b;
    if (cycles >= 20000) begin
      total_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", c_a + c_b + 1, total_fail);
    $finish;
  end
endmodule